// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block sets the wait before a half-duplex Ethernet transmitter tries a frame again after a collision, and it decides when the frame is abandoned. Each collision that the block accepts raises the attempt count. The block then picks a random number of slot times inside a range set by the backoff mode. It holds a busy flag while it counts those slots and gives a one-cycle retry strobe when the wait ends. One slot is 512 bit times. With a 50 MHz clock that is 256 cycles at 100 Mb/s and 2560 cycles at 10 Mb/s. Both lengths are parameters.

Four modes select the delay rule. The standard rule is truncated binary exponential backoff with the exponent capped at 10. A shortened rule keeps the standard range for the first two collisions and then limits the wait to at most three slots. A buffer-aware rule gives no wait while the port buffer reports full. The last rule never waits. A frame that meets its sixteenth collision is dropped unless the drop-disable input is set. A successful frame or a drop clears the attempt count. The random source is a free-running 16-bit LFSR whose low bits are masked to the range in force at each collision.

Top module: `hdx_backoff`

## Requirements
- R1: After reset, busy_o, retry_o and drop_o are all low.
- R2: An accepted collision raises busy_o at the next clock edge. busy_o stays high for exactly 1 + k*S cycles, where k is the chosen slot count. retry_o is high for one cycle, in the first cycle with busy_o low. S is SLOT_FAST cycles when fast_i=1 and SLOT_SLOW cycles when fast_i=0, sampled on the collision.
- R3: In mode_i=2'b00, the wait after the n-th collision of a frame is k in [0, 2^min(n,10) - 1] slots.
- R4: In mode_i=2'b01, collisions 1 and 2 follow the R3 range. Collision 3 and later use k in [0,3].
- R5: In mode_i=2'b10, k=0 when buf_full_i=1 on the collision. Otherwise the R3 range applies.
- R6: In mode_i=2'b11, k=0 always: busy_o is high for one cycle and then retry_o pulses.
- R7: With drop_dis_i=0, the 16th accepted collision of a frame gives a one-cycle drop_o in the next cycle and no busy_o and no retry_o. The attempt count then restarts, so the next collision counts as the first.
- R8: With drop_dis_i=1, drop_o never pulses. Retries continue past 16 collisions with the range capped at 1023 slots.
- R9: A done_i pulse clears the attempt count, so 16 further collisions are needed before a drop.
- R10: A col_i pulse while busy_o is high is ignored. It is not counted and it does not change the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| col_i | input | 1 | Collision strobe, one cycle |
| done_i | input | 1 | Frame sent successfully, one cycle |
| fast_i | input | 1 | 1: 100 Mb/s slot length, 0: 10 Mb/s slot length |
| mode_i | input | 2 | Backoff rule: 00 standard, 01 shortened, 10 zero-when-full, 11 zero |
| buf_full_i | input | 1 | Port buffer full |
| drop_dis_i | input | 1 | 1: never drop after 16 collisions |
| busy_o | output | 1 | Backoff wait in progress |
| retry_o | output | 1 | Wait expired, transmission may retry |
| drop_o | output | 1 | Frame abandoned after the collision limit |

## Verification
Frames are driven through long runs of collisions in every mode. The measured busy length is split into a whole number of slots and compared against the range the bench computes for that mode and attempt number. Zero-delay runs tell the buffer-aware and always-zero rules apart from the standard rule. A run at the slow speed shows that the slot length follows fast_i. Extra collision pulses injected at random into waits, and a done pulse in the middle of a frame, each move where the drop lands. They show whether ignored collisions or a missed clear change the attempt count. A maximum-range check at high attempt numbers confirms that the range actually widens beyond three slots in standard mode.

// File: rtl/hdx_backoff_pkg.sv
package hdx_backoff_pkg;
  typedef enum logic [1:0] {
    BO_STD       = 2'b00,
    BO_SHORT     = 2'b01,
    BO_ZERO_FULL = 2'b10,
    BO_ZERO      = 2'b11
  } bo_mode_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/hdx_bo_lfsr.sv
module hdx_bo_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] rnd_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else if (q[0]) q <= (q >> 1) ^ TAPS;
    else q <= q >> 1;
  end

  assign rnd_o = q;

  AST_LFSR_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0); // R3
endmodule

// File: rtl/hdx_bo_policy.sv
module hdx_bo_policy
  import hdx_backoff_pkg::*;
#(
  parameter int unsigned ATTEMPT_LIMIT = 16,
  parameter int unsigned EXP_CAP       = 10,
  parameter int unsigned SHORT_AFTER   = 2,
  parameter int unsigned SHORT_BITS    = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               col_acc_i,
  input  logic               done_i,
  input  bo_mode_e           mode_i,
  input  logic               buf_full_i,
  input  logic               drop_dis_i,
  output logic               drop_now_o,
  output logic [EXP_CAP-1:0] mask_o
);
  localparam int unsigned CNT_W = $clog2(ATTEMPT_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   n_nxt;
  logic [CNT_W:0]   exp_v;
  logic [EXP_CAP-1:0] std_mask, short_mask;

  assign n_nxt = {1'b0, cnt} + 1'b1;
  assign exp_v = (n_nxt > (CNT_W+1)'(EXP_CAP)) ? (CNT_W+1)'(EXP_CAP) : n_nxt;
  assign drop_now_o = !drop_dis_i && (n_nxt >= (CNT_W+1)'(ATTEMPT_LIMIT));

  always_comb begin
    for (int i = 0; i < int'(EXP_CAP); i++) begin
      std_mask[i]   = (i < int'(exp_v));
      short_mask[i] = (i < int'(SHORT_BITS));
    end
  end

  always_comb begin
    unique case (mode_i)
      BO_STD:       mask_o = std_mask;
      BO_SHORT:     mask_o = (n_nxt > (CNT_W+1)'(SHORT_AFTER)) ? short_mask : std_mask;
      BO_ZERO_FULL: mask_o = buf_full_i ? '0 : std_mask;
      default:      mask_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (done_i) cnt <= '0;
    else if (col_acc_i) begin
      if (drop_now_o) cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (cnt == '0)); // R9
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_acc_i && drop_now_o && !done_i) |=> (cnt == '0)); // R7
  AST_SHORT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == BO_SHORT && cnt >= CNT_W'(SHORT_AFTER)) |-> (mask_o == short_mask)); // R4
endmodule

// File: rtl/hdx_bo_timer.sv
module hdx_bo_timer #(
  parameter int unsigned SLOT_FAST = 256,
  parameter int unsigned SLOT_SLOW = 2560,
  parameter int unsigned RAND_W    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RAND_W-1:0] slots_i,
  input  logic              fast_i,
  output logic              busy_o,
  output logic              expire_o
);
  localparam int unsigned SLOT_MAX = (SLOT_SLOW > SLOT_FAST) ? SLOT_SLOW : SLOT_FAST;
  localparam int unsigned LEN_W = $clog2(SLOT_MAX + 1);

  logic [LEN_W-1:0]  slot_len, cyc;
  logic [RAND_W-1:0] left;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      expire_o <= 1'b0;
      slot_len <= LEN_W'(SLOT_FAST);
      cyc      <= '0;
      left     <= '0;
    end else begin
      expire_o <= 1'b0;
      if (load_i && !busy_o) begin
        busy_o   <= 1'b1;
        left     <= slots_i;
        cyc      <= '0;
        slot_len <= fast_i ? LEN_W'(SLOT_FAST) : LEN_W'(SLOT_SLOW);
      end else if (busy_o) begin
        if (left == '0) begin
          busy_o   <= 1'b0;
          expire_o <= 1'b1;
        end else if (cyc == slot_len - 1'b1) begin
          cyc  <= '0;
          left <= left - 1'b1;
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

  AST_EXPIRE_ENDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |-> (!busy_o && $past(busy_o))); // R2
  AST_CYC_IN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cyc < slot_len)); // R2
  AST_WAIT_STABLE_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(slot_len)); // R10
endmodule

// File: rtl/hdx_backoff.sv
module hdx_backoff
  import hdx_backoff_pkg::*;
#(
  parameter int unsigned SLOT_FAST     = 256,
  parameter int unsigned SLOT_SLOW     = 2560,
  parameter int unsigned ATTEMPT_LIMIT = 16,
  parameter int unsigned EXP_CAP       = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       col_i,
  input  logic       done_i,
  input  logic       fast_i,
  input  logic [1:0] mode_i,
  input  logic       buf_full_i,
  input  logic       drop_dis_i,
  output logic       busy_o,
  output logic       retry_o,
  output logic       drop_o
);
  logic [LFSR_W-1:0]  rnd;
  logic [EXP_CAP-1:0] mask, slots;
  logic               col_acc, drop_now, load;
  bo_mode_e           mode;

  assign mode    = bo_mode_e'(mode_i);
  assign col_acc = col_i && !busy_o;
  assign slots   = rnd[EXP_CAP-1:0] & mask;
  assign load    = col_acc && !drop_now;

  hdx_bo_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(16'hACE1)) i_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rnd_o (rnd)
  );

  hdx_bo_policy #(
    .ATTEMPT_LIMIT(ATTEMPT_LIMIT),
    .EXP_CAP      (EXP_CAP),
    .SHORT_AFTER  (2),
    .SHORT_BITS   (2)
  ) i_policy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .col_acc_i (col_acc),
    .done_i    (done_i),
    .mode_i    (mode),
    .buf_full_i(buf_full_i),
    .drop_dis_i(drop_dis_i),
    .drop_now_o(drop_now),
    .mask_o    (mask)
  );

  hdx_bo_timer #(
    .SLOT_FAST(SLOT_FAST),
    .SLOT_SLOW(SLOT_SLOW),
    .RAND_W   (EXP_CAP)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .slots_i (slots),
    .fast_i  (fast_i),
    .busy_o  (busy_o),
    .expire_o(retry_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drop_o <= 1'b0;
    else drop_o <= col_acc && drop_now;
  end

  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, retry_o, drop_o})); // R7
  AST_ZERO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && mode == BO_ZERO) |=> (busy_o ##1 retry_o)); // R6
  AST_NO_DROP_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_acc && drop_dis_i) |=> !drop_o); // R8
  AST_START_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> busy_o); // R2
  AST_FULL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_acc && mode == BO_ZERO_FULL && buf_full_i) |-> (slots == '0)); // R5
endmodule

// File: tb/test_hdx_backoff.sv
module test_hdx_backoff;
  localparam int SF = 4;
  localparam int SS = 40;
  localparam int WD = 190000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic col_i = 1'b0, done_i = 1'b0, fast_i = 1'b1, buf_full_i = 1'b0, drop_dis_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic busy_o, retry_o, drop_o;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;

  hdx_backoff #(.SLOT_FAST(SF), .SLOT_SLOW(SS)) i_hdx_backoff (
    .clk_i(clk_i), .rst_ni(rst_ni), .col_i(col_i), .done_i(done_i), .fast_i(fast_i),
    .mode_i(mode_i), .buf_full_i(buf_full_i), .drop_dis_i(drop_dis_i),
    .busy_o(busy_o), .retry_o(retry_o), .drop_o(drop_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt == WD) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc_cnt, WD);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int max_k(input int m, input int n, input bit bf);
    int s;
    s = (1 << (n > 10 ? 10 : n)) - 1;
    case (m)
      0: return s;
      1: return (n <= 2) ? s : 3;
      2: return bf ? 0 : s;
      default: return 0;
    endcase
  endfunction

  // one collision; returns slot count k, or -1 on drop
  task automatic do_col(input bit inj, output int k);
    int len;
    int slot;
    slot = fast_i ? SF : SS;
    @(negedge clk_i) col_i = 1'b1;
    @(negedge clk_i) col_i = 1'b0;
    if (drop_o) begin
      k = -1;
      chk(!busy_o, "R7 busy on drop", int'(busy_o), 0);
      @(negedge clk_i);
      chk(!drop_o && !retry_o, "R7 single drop", int'(drop_o), 0);
      return;
    end
    len = 0;
    while (busy_o && len < 50000) begin
      len++;
      col_i = (inj && len == 2);
      @(negedge clk_i);
    end
    col_i = 1'b0;
    chk(len >= 1, "R2 busy raised", len, 1);
    chk(retry_o == 1'b1, "R2 retry after wait", int'(retry_o), 1);
    chk(((len - 1) % slot) == 0, "R2 whole slots", (len - 1) % slot, 0);
    k = (len - 1) / slot;
  endtask

  task automatic pulse_done();
    @(negedge clk_i) done_i = 1'b1;
    @(negedge clk_i) done_i = 1'b0;
  endtask

  initial begin
    int k;
    int big;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !retry_o && !drop_o, "R1 reset", int'({busy_o, retry_o, drop_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !retry_o && !drop_o, "R1 after reset", int'({busy_o, retry_o, drop_o}), 0);

    // R3 R7 R10: standard mode, 16 counted collisions with ignored injections
    mode_i = 2'b00; drop_dis_i = 1'b0; fast_i = 1'b1; big = 0;
    for (int n = 1; n <= 15; n++) begin
      do_col(bit'($urandom % 2), k);
      chk(k >= 0 && k <= max_k(0, n, 0), "R3 std range", k, max_k(0, n, 0));
      if (n >= 4 && k > big) big = k;
    end
    chk(big > 3, "R3 range widens", big, 4);
    do_col(1'b0, k);
    chk(k == -1, "R7 drop on 16th / R10 ignored pulses", k, -1);
    do_col(1'b0, k);
    chk(k >= 0 && k <= 1, "R7 count restarts", k, 1);
    pulse_done();

    // R2 slow slot length
    fast_i = 1'b0; big = 0;
    for (int n = 1; n <= 3; n++) begin
      do_col(1'b0, k);
      chk(k >= 0 && k <= max_k(0, n, 0), "R2 slow range", k, max_k(0, n, 0));
      if (k > big) big = k;
    end
    if (big == 0) begin
      do_col(1'b0, k);
      big = k;
    end
    pulse_done();
    fast_i = 1'b1;

    // R4 shortened mode
    mode_i = 2'b01; drop_dis_i = 1'b1;
    for (int n = 1; n <= 10; n++) begin
      do_col(bit'($urandom % 2), k);
      chk(k >= 0 && k <= max_k(1, n, 0), "R4 short range", k, max_k(1, n, 0));
    end
    pulse_done();

    // R5 zero while buffer full, standard otherwise
    mode_i = 2'b10; buf_full_i = 1'b1;
    for (int n = 1; n <= 5; n++) begin
      do_col(1'b0, k);
      chk(k == 0, "R5 full zero", k, 0);
    end
    buf_full_i = 1'b0;
    for (int n = 6; n <= 7; n++) begin
      do_col(1'b0, k);
      chk(k >= 0 && k <= max_k(2, n, 0), "R5 not full range", k, max_k(2, n, 0));
    end
    pulse_done();

    // R8 no drop beyond 16 with range cap
    mode_i = 2'b00; drop_dis_i = 1'b1;
    for (int n = 1; n <= 18; n++) begin
      do_col(1'b0, k);
      chk(k >= 0 && k <= max_k(0, n, 0), "R8 retries continue", k, max_k(0, n, 0));
    end
    pulse_done();

    // R6 R9: zero mode, done mid-frame resets attempt count
    mode_i = 2'b11; drop_dis_i = 1'b0;
    for (int n = 1; n <= 15; n++) begin
      do_col(1'b0, k);
      chk(k == 0, "R6 zero wait", k, 0);
    end
    pulse_done();
    for (int n = 1; n <= 15; n++) begin
      do_col(1'b0, k);
      chk(k == 0, "R9 no early drop", k, 0);
    end
    do_col(1'b0, k);
    chk(k == -1, "R9 drop after fresh 16", k, -1);

    repeat (4) @(negedge clk_i);
    chk(!busy_o && !retry_o && !drop_o, "R2 idle at end", int'({busy_o, retry_o, drop_o}), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule